// File: doc/BRIEF.md
# Seven-Pin Input Conditioner with Noise Filter

This block conditions the seven input pins of one port on a small 8-bit microcontroller. Every pin first passes through a two-flop synchroniser. Pins with filtering enabled then pass through a run-length noise filter. That filter accepts a new level only after the synchronised input has disagreed with the current output on three consecutive sampling strobes. Pins without filtering, which include the two pins that have no filter bit at all, follow the synchronised level directly.

Three byte-wide control registers sit on a plain register bus with a single-cycle write strobe and combinational read data. One register selects the pull-up per pin, one selects open-drain or push-pull per pin, and one enables filtering on a sparse set of pins. The pull-up and open-drain selections are driven out as per-pin control vectors for the pad logic. While the stop-mode input is high, every pin bypasses its filter. When stop mode ends, filtering resumes without creating a spurious edge.

Top module: `pin_conditioner`

## Requirements
- R1: After reset the pull-up register reads 00h and the open-drain register reads 78h, so pins 6..3 are open-drain and pins 2..0 are push-pull. The filter-enable register reads 00h, and all filtered levels are 0.
- R2: A write strobe with address 96h loads the pull-up register, address 95h loads the open-drain register, and address A7h loads the filter-enable register. The new value appears on the next clock edge. Bit i of each register controls pin i, and `pullup_en`/`opendrain_en` present bits 6..0 of their registers.
- R3: In the filter-enable register only bits 5, 4, 3, 1 and 0 are writable, and all other bits read 0. Bit 7 of the pull-up and open-drain registers reads 0. A read from any other address returns 00h.
- R4: On a pin whose filter is active, `pin_level` changes only on the third consecutive sampling strobe at which the synchronised input differs from `pin_level`. A strobe at which they agree restarts the run. With the strobe held high, a level change on `pin_raw` reaches `pin_level` five clock edges after it is applied.
- R5: On a filtered pin, a pulse that lasts fewer than three sampling strobes never reaches `pin_level`. A pulse that lasts three strobes does reach it.
- R6: The filter counts only on clock edges where `sample_tick` is high. Without a strobe, a filtered pin holds its level for any length of time.
- R7: A pin whose filter-enable bit is 0, including pins 2 and 6, which have no such bit, drives its `pin_raw` level onto `pin_level` three clock edges after it is applied, even for a single-cycle pulse.
- R8: While `stop_mode` is high, every pin behaves as in R7 and its run is cleared. After `stop_mode` falls, the output keeps the current input level, and any later change again needs three fresh strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_wr | input | 1 | Single-cycle register write strobe |
| sfr_addr | input | 8 | Register address for read and write |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Combinational read data for `sfr_addr` |
| pin_raw | input | 7 | Asynchronous pin levels |
| sample_tick | input | 1 | Sampling strobe for the noise filter |
| stop_mode | input | 1 | High while the device is in stop mode |
| pin_level | output | 7 | Conditioned pin levels |
| pullup_en | output | 7 | Per-pin pull-up enable |
| opendrain_en | output | 7 | Per-pin open-drain select (1) or push-pull (0) |

## Verification
The case that matters is stop mode rising on the same clock edge as a filter run that is one strobe short of accepting a new level. The bench builds a run of two mismatching strobes on pin 5 and then raises `stop_mode` exactly at the edge that would have been the third. It checks that the output takes the input level at that edge through the bypass path, and that after `stop_mode` falls the output holds without an extra edge. A following change on the same pin must then wait the full five edges. Checking at four edges and again at five separates a run that was cleared from one left over from before stop mode.

// File: rtl/pin_cond_pkg.sv
// Shared constants for the pin conditioner: pin count, register addresses,
// reset values and the mask of pins that own a filter-enable bit.
package pin_cond_pkg;
    localparam int          NPINS          = 7;
    localparam int          RUN_LEN        = 3;
    localparam logic [7:0]  ADDR_PULLUP    = 8'h96;
    localparam logic [7:0]  ADDR_OPENDRAIN = 8'h95;
    localparam logic [7:0]  ADDR_FILTER    = 8'hA7;
    localparam logic [7:0]  RST_PULLUP     = 8'h00;
    localparam logic [7:0]  RST_OPENDRAIN  = 8'h78;
    localparam logic [7:0]  RST_FILTER     = 8'h00;
    localparam logic [7:0]  FILTER_MASK    = 8'h3B;
endpackage

// File: rtl/pin_cond_regs.sv
// Control register bank: pull-up, open-drain and filter-enable registers.
// Assumes a single-cycle write strobe. Read data is combinational on the address.
module pin_cond_regs
    import pin_cond_pkg::*;
#(
    parameter int N = NPINS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [7:0]   addr,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    output logic [N-1:0] pu_q,
    output logic [N-1:0] od_q,
    output logic [N-1:0] flt_q
);
    localparam logic [N-1:0] FMASK = FILTER_MASK[N-1:0];

    // Register update on an addressed write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_q  <= RST_PULLUP[N-1:0];
            od_q  <= RST_OPENDRAIN[N-1:0];
            flt_q <= RST_FILTER[N-1:0];
        end else if (wr) begin
            case (addr)
                ADDR_PULLUP:    pu_q  <= wdata[N-1:0];
                ADDR_OPENDRAIN: od_q  <= wdata[N-1:0];
                ADDR_FILTER:    flt_q <= wdata[N-1:0] & FMASK;
                default: ;
            endcase
        end
    end

    // Read multiplexer, zero for unmapped addresses and unused bits
    always_comb begin
        case (addr)
            ADDR_PULLUP:    rdata = 8'(pu_q);
            ADDR_OPENDRAIN: rdata = 8'(od_q);
            ADDR_FILTER:    rdata = 8'(flt_q);
            default:        rdata = 8'h00;
        endcase
    end

    assert_pullup_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_PULLUP) |=> (pu_q == $past(wdata[N-1:0])));

    assert_opendrain_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_OPENDRAIN) |=> (od_q == $past(wdata[N-1:0])));

    assert_filter_unused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_FILTER) |=> ((flt_q & ~FMASK) == '0));
endmodule

// File: rtl/pin_cond_sync.sv
// Two-flop synchroniser for a vector of asynchronous pin inputs.
// Assumes every bit is an independent slow level; no bus coherence is implied.
module pin_cond_sync #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta;

    // Two-stage capture of the raw pin levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pin_cond_filter.sv
// Single-pin run-length noise filter. While active, the output takes a new
// level on the RUN_LEN-th consecutive strobe at which the input disagrees
// with it. While inactive (filter off or stop mode), the output copies the
// input every clock and the run counter stays cleared.
module pin_cond_filter
    import pin_cond_pkg::*;
#(
    parameter int RUN = RUN_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic stop,
    input  logic tick,
    input  logic s_in,
    output logic level
);
    localparam int CW = (RUN > 1) ? $clog2(RUN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN - 1);

    logic          active;
    logic [CW-1:0] run;

    assign active = enable && !stop;

    // Run counter and filtered level update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= '0;
            level <= 1'b0;
        end else if (!active) begin
            run   <= '0;
            level <= s_in;
        end else if (tick) begin
            if (s_in == level) begin
                run <= '0;
            end else if (run == LAST) begin
                run   <= '0;
                level <= s_in;
            end else begin
                run <= run + 1'b1;
            end
        end
    end

    assert_accept_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && level != $past(level)) |-> ($past(tick) && $past(run) == LAST));

    assert_run_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        run <= LAST);

    assert_no_tick_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && !$past(tick)) |-> $stable(level));

    assert_stop_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop) |-> (level == $past(s_in) && run == '0));
endmodule

// File: rtl/pin_conditioner.sv
// Top of the port input conditioner: register bank, synchroniser and one
// noise filter per pin. A pin is filtered only if its filter-enable bit
// exists and is set. Stop mode bypasses all filters.
module pin_conditioner
    import pin_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sfr_wr,
    input  logic [7:0]       sfr_addr,
    input  logic [7:0]       sfr_wdata,
    output logic [7:0]       sfr_rdata,
    input  logic [NPINS-1:0] pin_raw,
    input  logic             sample_tick,
    input  logic             stop_mode,
    output logic [NPINS-1:0] pin_level,
    output logic [NPINS-1:0] pullup_en,
    output logic [NPINS-1:0] opendrain_en
);
    logic [NPINS-1:0] flt_q;
    logic [NPINS-1:0] synced;

    pin_cond_regs #(.N(NPINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (sfr_wr),
        .addr  (sfr_addr),
        .wdata (sfr_wdata),
        .rdata (sfr_rdata),
        .pu_q  (pullup_en),
        .od_q  (opendrain_en),
        .flt_q (flt_q)
    );

    pin_cond_sync #(.N(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (synced)
    );

    // One filter per pin
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_cond_filter #(.RUN(RUN_LEN)) u_filter (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (flt_q[i]),
            .stop   (stop_mode),
            .tick   (sample_tick),
            .s_in   (synced[i]),
            .level  (pin_level[i])
        );
    end

    assert_unmapped_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr != ADDR_PULLUP && sfr_addr != ADDR_OPENDRAIN && sfr_addr != ADDR_FILTER)
        |-> (sfr_rdata == 8'h00));
endmodule

// File: tb/pin_conditioner_bench.sv
module pin_conditioner_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic [6:0] pin_raw = 7'h00;
    logic       sample_tick = 1'b1;
    logic       stop_mode = 1'b0;
    logic [6:0] pin_level;
    logic [6:0] pullup_en;
    logic [6:0] opendrain_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        int         kind;
        logic [7:0] mask;
        logic [7:0] exp;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    pin_conditioner u_pin_conditioner (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .pin_raw(pin_raw),
        .sample_tick(sample_tick), .stop_mode(stop_mode), .pin_level(pin_level),
        .pullup_en(pullup_en), .opendrain_en(opendrain_en)
    );

    // Monitor: pops expected items and compares with the live outputs
    initial begin
        forever begin
            item_t it;
            logic [7:0] act;
            wait (sb.size() > 0);
            it = sb.pop_front();
            case (it.kind)
                0: act = {1'b0, pin_level};
                1: act = {1'b0, pullup_en};
                2: act = {1'b0, opendrain_en};
                default: act = sfr_rdata;
            endcase
            checks++;
            if ((act & it.mask) !== (it.exp & it.mask)) begin
                fails++;
                $display("FAIL %s: actual %02h expected %02h (mask %02h)",
                         it.tag, act & it.mask, it.exp & it.mask, it.mask);
            end
        end
    end

    task automatic expect_item(input string tag, input int kind,
                               input logic [7:0] mask, input logic [7:0] exp);
        item_t it;
        it.tag = tag; it.kind = kind; it.mask = mask; it.exp = exp;
        sb.push_back(it);
        #1;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        step(1);
        sfr_wr = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [7:0] a, input logic [7:0] exp);
        sfr_addr = a;
        #1;
        expect_item(tag, 3, 8'hFF, exp);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        expect_item("R1 pullup reset", 1, 8'h7F, 8'h00);
        expect_item("R1 opendrain reset", 2, 8'h7F, 8'h78);
        expect_item("R1 level reset", 0, 8'h7F, 8'h00);
        read_check("R1 read pullup", 8'h96, 8'h00);
        read_check("R1 read opendrain", 8'h95, 8'h78);
        read_check("R1 read filter", 8'hA7, 8'h00);
        read_check("R3 unmapped read", 8'h42, 8'h00);

        // R2 / R3 register writes
        sfr_write(8'h96, 8'hFF);
        expect_item("R2 pullup write", 1, 8'h7F, 8'h7F);
        read_check("R3 pullup bit7 reads 0", 8'h96, 8'h7F);
        sfr_write(8'h95, 8'h05);
        expect_item("R2 opendrain write", 2, 8'h7F, 8'h05);
        sfr_write(8'hA7, 8'hFF);
        read_check("R3 filter mask", 8'hA7, 8'h3B);
        sfr_write(8'h40, 8'hFF);
        read_check("R3 unmapped write no effect", 8'h96, 8'h7F);

        // R7 unfiltered pin 6: single-cycle pulse, three-edge latency
        pin_raw[6] = 1'b1;
        step(1);
        pin_raw[6] = 1'b0;
        step(1);
        expect_item("R7 pin6 before latency", 0, 8'h40, 8'h00);
        step(1);
        expect_item("R7 pin6 pulse passes", 0, 8'h40, 8'h40);
        step(1);
        expect_item("R7 pin6 pulse ends", 0, 8'h40, 8'h00);

        // R4 filtered pin 0: five-edge latency
        pin_raw[0] = 1'b1;
        step(4);
        expect_item("R4 pin0 not yet", 0, 8'h01, 8'h00);
        step(1);
        expect_item("R4 pin0 accepted", 0, 8'h01, 8'h01);

        // R5 pulse of two strobes rejected on pin 1
        pin_raw[1] = 1'b1;
        step(2);
        pin_raw[1] = 1'b0;
        step(8);
        expect_item("R5 short pulse rejected", 0, 8'h02, 8'h00);
        // R5 pulse of three strobes accepted
        pin_raw[1] = 1'b1;
        step(3);
        pin_raw[1] = 1'b0;
        step(2);
        expect_item("R5 three-strobe pulse accepted", 0, 8'h02, 8'h02);
        step(5);
        expect_item("R5 pulse release filtered", 0, 8'h02, 8'h00);

        // R6 no strobe, no count on pin 3
        sample_tick = 1'b0;
        pin_raw[3] = 1'b1;
        step(12);
        expect_item("R6 hold without strobe", 0, 8'h08, 8'h00);
        for (int k = 0; k < 2; k++) begin
            sample_tick = 1'b1; step(1); sample_tick = 1'b0; step(3);
        end
        expect_item("R6 two strobes insufficient", 0, 8'h08, 8'h00);
        sample_tick = 1'b1; step(1); sample_tick = 1'b0; step(1);
        expect_item("R6 third strobe accepts", 0, 8'h08, 8'h08);
        sample_tick = 1'b1;

        // R8 stop mode bypass on pin 4
        stop_mode = 1'b1;
        pin_raw[4] = 1'b1;
        step(1);
        pin_raw[4] = 1'b0;
        step(2);
        expect_item("R8 stop bypass pulse", 0, 8'h10, 8'h10);
        step(1);
        expect_item("R8 stop bypass pulse ends", 0, 8'h10, 8'h00);
        stop_mode = 1'b0;
        step(6);
        expect_item("R8 no edge on exit", 0, 8'h10, 8'h00);

        // R8 collision: stop rises on the edge that would be the third strobe
        pin_raw[5] = 1'b1;
        step(4);
        stop_mode = 1'b1;
        step(1);
        expect_item("R8 collision bypass level", 0, 8'h20, 8'h20);
        stop_mode = 1'b0;
        step(3);
        expect_item("R8 collision holds after exit", 0, 8'h20, 8'h20);
        pin_raw[5] = 1'b0;
        step(4);
        expect_item("R8 fresh run needed", 0, 8'h20, 8'h20);
        step(1);
        expect_item("R8 fresh run accepted", 0, 8'h20, 8'h00);

        // R7 clearing the enable bit makes pin 4 unfiltered
        sfr_write(8'hA7, 8'h2F);
        read_check("R3 filter rewrite", 8'hA7, 8'h2B);
        pin_raw[4] = 1'b1;
        step(1);
        pin_raw[4] = 1'b0;
        step(2);
        expect_item("R7 disabled pin4 bypass", 0, 8'h10, 8'h10);

        step(2);
        wait (sb.size() == 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule